// File: doc/BRIEF.md
# Banked Register File Address Mapper

This block is a byte-wide data register file of four banks of 128 locations each. An access names its location in one of two ways. A direct access gives a 7-bit offset together with two bank-select bits taken from the status register. An indirect access gives an 8-bit pointer value together with one extra high bank bit. Either way the block forms a 9-bit file address, works out which region that address falls in, and then reaches the physical byte behind it.

Offsets 00h–1Fh of every bank are special-function register slots. The block stores none of them. It forwards the address, the strobes and the write data for those slots to an outside port, and it returns the read data that comes back on that port. Offsets 20h–6Fh are private static RAM, a separate set for each bank. Offsets 70h–7Fh form a 16-byte common window. Banks 1 to 3 fold that window onto the bank 0 bytes, so all four banks share the same 16 bytes.

Writes take effect at the clock edge. Reads are combinational.

Top module: `bank_regfile_mapper`

## Requirements
- R1: In direct mode (`ind_sel`=0) the file address is {`rp`[1:0], `dir_offs`[6:0]}. `rp` 00/01/10/11 selects bank 0/1/2/3, which is address range 000h/080h/100h/180h plus the offset. `rp`[1] is status bit 6 and `rp`[0] is status bit 5.
- R2: In indirect mode (`ind_sel`=1) the file address is {`ind_bank`, `ptr`[7:0]}. Bit 7 of `ptr` is therefore the low bank bit, and `ptr`[6:0] is the offset.
- R3: An offset below 20h raises `sfr_sel` and puts the 9-bit file address on `sfr_addr`. In that case `sfr_wr` equals `wr_en`, `sfr_rd` equals `rd_en`, `sfr_wdata` equals `wdata`, and a read returns `sfr_rdata`. No RAM byte changes.
- R4: Offsets 20h–6Fh are private to each bank. A write there in one bank is not visible at the same offset in any other bank.
- R5: Offsets 70h–7Fh are one shared window. A write there through any bank, in either mode, is read back at the same offset in all four banks.
- R6: A write with `wr_en`=1 lands at the rising clock edge. The read path is combinational, so a read in the next cycle returns the new value.
- R7: When `rd_en`=0, `rdata` is 00h.
- R8: After reset, every RAM location reads 00h.
- R9: When `wr_en`=0, no RAM location changes, whatever `wdata` holds. `sfr_wr` stays 0 while `sfr_sel` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; clears the RAM |
| ind_sel | input | 1 | 0 = direct access, 1 = indirect access |
| rp | input | 2 | Bank-select bits for direct access |
| dir_offs | input | 7 | Offset for direct access |
| ind_bank | input | 1 | High bank bit for indirect access |
| ptr | input | 8 | Pointer value for indirect access |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data (combinational) |
| sfr_sel | output | 1 | The address falls in the special-function register region |
| sfr_addr | output | 9 | File address forwarded to the special-function register logic |
| sfr_rd | output | 1 | Forwarded read strobe |
| sfr_wr | output | 1 | Forwarded write strobe |
| sfr_wdata | output | 8 | Forwarded write data |
| sfr_rdata | input | 8 | Read data returned by the special-function register logic |

## Verification
The bench goes after the offset boundaries 1Fh/20h and 6Fh/70h, where a wrong region decode either drops a RAM access onto the outside port or writes RAM where it should not. It writes the common window through bank 3 and reads it back through the other banks and through the pointer path. A design that folded the window wrongly, or not at all, would return 00h or a stale byte there. It checks that private bytes stay private, so a mapper that ignored the bank bits would leak data between banks. It also checks that indirect accesses take their low bank bit from pointer bit 7; a swapped bank bit shows up as data in the wrong bank.

// File: rtl/bank_map_pkg.sv
package bank_map_pkg;
  localparam int DATA_W      = 8;
  localparam int OFFS_W      = 7;
  localparam int BANK_W      = 2;
  localparam int ADDR_W      = OFFS_W + BANK_W;
  localparam int BANKS       = 1 << BANK_W;
  localparam int SFR_LIMIT   = 32;
  localparam int COMMON_SIZE = 16;
  localparam int COMMON_BASE = (1 << OFFS_W) - COMMON_SIZE;
  localparam int BANK_RAM    = (1 << OFFS_W) - SFR_LIMIT;
  localparam int PRIV_RAM    = COMMON_BASE - SFR_LIMIT;
  localparam int RAM_DEPTH   = BANK_RAM + (BANKS - 1) * PRIV_RAM;
  localparam int IDX_W       = $clog2(RAM_DEPTH);

  typedef logic [ADDR_W-1:0] faddr_t;

  function automatic faddr_t form_direct(input logic [BANK_W-1:0] bsel,
                                         input logic [OFFS_W-1:0] offs);
    return {bsel, offs};
  endfunction

  function automatic faddr_t form_indirect(input logic hi_bank,
                                           input logic [OFFS_W:0] pval);
    return {hi_bank, pval};
  endfunction

  function automatic logic in_sfr(input faddr_t a);
    return int'(a[OFFS_W-1:0]) < SFR_LIMIT;
  endfunction

  function automatic logic in_common(input faddr_t a);
    return int'(a[OFFS_W-1:0]) >= COMMON_BASE;
  endfunction

  function automatic logic [IDX_W-1:0] phys_index(input faddr_t a);
    int offs;
    int bank;
    int idx;
    offs = int'(a[OFFS_W-1:0]);
    bank = int'(a[ADDR_W-1:OFFS_W]);
    if (offs < SFR_LIMIT)
      idx = 0;
    else if (bank == 0 || offs >= COMMON_BASE)
      idx = offs - SFR_LIMIT;
    else
      idx = BANK_RAM + (bank - 1) * PRIV_RAM + (offs - SFR_LIMIT);
    return IDX_W'(idx);
  endfunction
endpackage

// File: rtl/addr_resolve.sv
module addr_resolve
  import bank_map_pkg::*;
(
  input  logic                ind_sel,
  input  logic [BANK_W-1:0]   rp,
  input  logic [OFFS_W-1:0]   dir_offs,
  input  logic                ind_bank,
  input  logic [OFFS_W:0]     ptr,
  output faddr_t              full_addr,
  output logic                hit_sfr,
  output logic                hit_common,
  output logic [IDX_W-1:0]    ram_idx
);
  always_comb begin
    full_addr  = ind_sel ? form_indirect(ind_bank, ptr) : form_direct(rp, dir_offs);
    hit_sfr    = in_sfr(full_addr);
    hit_common = in_common(full_addr);
    ram_idx    = phys_index(full_addr);
  end
endmodule

// File: rtl/ram_store.sv
module ram_store
  import bank_map_pkg::*;
#(
  parameter int DEPTH = RAM_DEPTH,
  parameter int DW    = DATA_W,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] idx,
  input  logic [DW-1:0] wd,
  output logic [DW-1:0] rd
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (we) begin
      mem[idx] <= wd;
    end
  end

  assign rd = mem[idx];

  // R6
  write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> mem[$past(idx)] == $past(wd));
endmodule

// File: rtl/bank_regfile_mapper.sv
module bank_regfile_mapper
  import bank_map_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ind_sel,
  input  logic [1:0]         rp,
  input  logic [6:0]         dir_offs,
  input  logic               ind_bank,
  input  logic [7:0]         ptr,
  input  logic               rd_en,
  input  logic               wr_en,
  input  logic [7:0]         wdata,
  output logic [7:0]         rdata,
  output logic               sfr_sel,
  output logic [8:0]         sfr_addr,
  output logic               sfr_rd,
  output logic               sfr_wr,
  output logic [7:0]         sfr_wdata,
  input  logic [7:0]         sfr_rdata
);
  faddr_t           full_addr;
  logic             hit_sfr;
  logic             hit_common;
  logic [IDX_W-1:0] ram_idx;
  logic             ram_we;
  logic [7:0]       ram_q;

  addr_resolve u_res (
    .ind_sel    (ind_sel),
    .rp         (rp),
    .dir_offs   (dir_offs),
    .ind_bank   (ind_bank),
    .ptr        (ptr),
    .full_addr  (full_addr),
    .hit_sfr    (hit_sfr),
    .hit_common (hit_common),
    .ram_idx    (ram_idx)
  );

  assign ram_we = wr_en && !hit_sfr;

  ram_store #(.DEPTH(RAM_DEPTH), .DW(DATA_W)) u_ram (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (ram_we),
    .idx   (ram_idx),
    .wd    (wdata),
    .rd    (ram_q)
  );

  assign sfr_sel   = hit_sfr;
  assign sfr_addr  = full_addr;
  assign sfr_rd    = rd_en && hit_sfr;
  assign sfr_wr    = wr_en && hit_sfr;
  assign sfr_wdata = wdata;

  always_comb begin
    if (!rd_en)       rdata = '0;
    else if (hit_sfr) rdata = sfr_rdata;
    else              rdata = ram_q;
  end

  // R4
  phys_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sfr_sel |-> int'(ram_idx) < RAM_DEPTH);

  // R5
  common_fold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit_common |-> (int'(ram_idx) >= COMMON_BASE - SFR_LIMIT && int'(ram_idx) < BANK_RAM));

  // R3
  sfr_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sfr_sel |-> int'(sfr_addr[6:0]) < SFR_LIMIT);

  // R7
  rd_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |-> rdata == 8'h00);

  // R9
  sfr_wr_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sfr_sel |-> !sfr_wr);
endmodule

// File: tb/bank_regfile_mapper_tb.sv
module bank_regfile_mapper_tb_top;
  logic clk = 0;
  logic rst_n = 0;
  logic ind_sel = 0, ind_bank = 0, rd_en = 0, wr_en = 0;
  logic [1:0] rp = 0;
  logic [6:0] dir_offs = 0;
  logic [7:0] ptr = 0, wdata = 0, sfr_rdata = 0;
  logic [7:0] rdata, sfr_wdata;
  logic sfr_sel, sfr_rd, sfr_wr;
  logic [8:0] sfr_addr;

  int checks = 0;
  int errors = 0;
  logic [7:0] model [int];

  always #2.5 clk = ~clk;

  bank_regfile_mapper dut_i (
    .clk(clk), .rst_n(rst_n), .ind_sel(ind_sel), .rp(rp), .dir_offs(dir_offs),
    .ind_bank(ind_bank), .ptr(ptr), .rd_en(rd_en), .wr_en(wr_en), .wdata(wdata),
    .rdata(rdata), .sfr_sel(sfr_sel), .sfr_addr(sfr_addr), .sfr_rd(sfr_rd),
    .sfr_wr(sfr_wr), .sfr_wdata(sfr_wdata), .sfr_rdata(sfr_rdata)
  );

  task automatic chk(input string req, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s got %0h expected %0h", req, got, exp);
    end
  endtask

  // bank 0 owns the shared window; every other location has its own key
  function automatic int key_of(input int bank, input int offs);
    if (offs >= 8'h70) return offs;
    return bank * 128 + offs;
  endfunction

  task automatic step(input string tag, input logic ind, input int bank_or_hb,
                      input int offs_or_ptr, input logic rd, input logic wr,
                      input int wd, input int sd);
    int addr, bank, offs, k, exp_rd;
    @(negedge clk);
    ind_sel = ind;
    if (ind) begin
      ind_bank = bank_or_hb[0];
      ptr = offs_or_ptr[7:0];
      addr = bank_or_hb[0] * 256 + offs_or_ptr[7:0];
    end else begin
      rp = bank_or_hb[1:0];
      dir_offs = offs_or_ptr[6:0];
      addr = bank_or_hb[1:0] * 128 + offs_or_ptr[6:0];
    end
    rd_en = rd; wr_en = wr; wdata = wd[7:0]; sfr_rdata = sd[7:0];
    #1;
    bank = addr / 128;
    offs = addr % 128;
    k = key_of(bank, offs);
    if (offs < 32) begin
      chk({tag, " R3 sfr_sel"}, sfr_sel, 1);
      chk({tag, ind ? " R2 sfr_addr" : " R1 sfr_addr"}, sfr_addr, addr);
      chk({tag, " R3 sfr_wr"}, sfr_wr, wr);
      chk({tag, " R3 sfr_rd"}, sfr_rd, rd);
      chk({tag, " R3 sfr_wdata"}, sfr_wdata, wd[7:0]);
      chk({tag, " R3/R7 rdata"}, rdata, rd ? sd[7:0] : 0);
    end else begin
      exp_rd = model.exists(k) ? int'(model[k]) : 0;
      chk({tag, " R3 sfr_sel"}, sfr_sel, 0);
      chk({tag, " R9 sfr_wr"}, sfr_wr, 0);
      chk({tag, offs >= 8'h70 ? " R5 rdata" : " R4 rdata"}, rdata, rd ? exp_rd : 0);
      if (wr) model[k] = wd[7:0];
    end
    @(posedge clk);
  endtask

  initial begin
    #900000;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    // R8 reset contents
    step("R8", 0, 2, 'h40, 1, 0, 0, 0);
    step("R8", 0, 3, 'h75, 1, 0, 0, 0);
    step("R8", 1, 1, 'h20, 1, 0, 0, 0);
    // R5 shared window written through bank 3
    step("R5", 0, 3, 'h78, 0, 1, 'hA5, 0);
    step("R5", 0, 0, 'h78, 1, 0, 0, 0);
    step("R5", 0, 1, 'h78, 1, 0, 0, 0);
    step("R5", 0, 2, 'h78, 1, 0, 0, 0);
    step("R5", 1, 1, 'hF8, 1, 0, 0, 0);
    step("R5", 1, 0, 'h78, 1, 0, 0, 0);
    // R4 private bytes, R2 pointer path, R6 read next cycle
    step("R6", 0, 1, 'h30, 0, 1, 'h3C, 0);
    step("R6", 1, 0, 'hB0, 1, 0, 0, 0);
    step("R4", 0, 0, 'h30, 1, 0, 0, 0);
    step("R4", 0, 2, 'h30, 1, 0, 0, 0);
    step("R4", 0, 3, 'h30, 1, 0, 0, 0);
    step("R2", 1, 1, 'h6F, 0, 1, 'h77, 0);
    step("R2", 0, 3, 'h6F, 1, 0, 0, 0);
    step("R2", 0, 2, 'h6F, 1, 0, 0, 0);
    // R9 write strobe low leaves data alone
    step("R9", 0, 1, 'h30, 0, 0, 'hEE, 0);
    step("R9", 0, 1, 'h30, 1, 0, 0, 0);
    // R7 read strobe low
    step("R7", 0, 1, 'h30, 0, 0, 0, 0);
    // R1/R3 boundaries 1Fh/20h and special-function forwarding
    step("R1", 0, 2, 'h05, 1, 1, 'h5A, 'hC3);
    step("R3", 0, 2, 'h1F, 1, 0, 0, 'h99);
    step("R3", 0, 2, 'h20, 1, 1, 'h11, 'h99);
    step("R3", 0, 2, 'h20, 1, 0, 0, 'h99);
    step("R3", 1, 1, 'h80, 1, 1, 'h42, 'h24);
    // random traffic compared against the model
    for (int i = 0; i < 4000; i++) begin
      logic ind;
      int b, o;
      ind = $urandom_range(0, 1) == 1;
      b = ind ? $urandom_range(0, 1) : $urandom_range(0, 3);
      o = ind ? $urandom_range(0, 255) : $urandom_range(0, 127);
      step("rand", ind, b, o, $urandom_range(0, 1) == 1, $urandom_range(0, 2) == 0,
           $urandom_range(0, 255), $urandom_range(0, 255));
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule